// File: doc/BRIEF.md
# Receive Polarity Detector and Corrector

This block watches the receive side of a 10 Mb/s twisted-pair link for signs that the two wires of the pair have been swapped, and, when allowed to, undoes the swap by inverting the recovered serial data. Upstream logic has already qualified link pulses and decoded frames. That logic supplies two kinds of strobe. The first is a strobe per received link pulse, with a bit giving that pulse's polarity. The second is a strobe per received end of frame, with a bit giving the sign of the tail that follows it.

A swap is declared only when both kinds of evidence agree. At least one inverted link pulse must have been seen, and the most recent frames must have ended with negative tails for a configurable number of frames in a row (four by default). The status flag then stays set until reset. A configuration input decides whether the data path inverts the bit stream once the swap is known. The status flag is reported either way.

Top module: `rx_polarity_fixer`

## Requirements
- R1: After reset, `pol_reversed` is 0 and `rxd_out` equals `rxd_in`.
- R2: Frames with negative tails alone, without any inverted link pulse, never set `pol_reversed`.
- R3: Inverted link pulses alone, without the required run of negative-tail frames, never set `pol_reversed`.
- R4: Once an inverted link pulse (`lp_stb`=1 with `lp_inv`=1) has been captured and RUN_THRESH consecutive negative-tail frames (`eof_stb`=1 with `eof_neg`=1) have been captured, `pol_reversed` rises on the next clock edge. The order in which the two kinds of evidence arrive does not matter.
- R5: A frame with a normal tail (`eof_stb`=1 with `eof_neg`=0) restarts the consecutive-frame run from zero.
- R6: The consecutive-frame count saturates at RUN_THRESH and does not wrap, however many negative-tail frames arrive.
- R7: An inverted link pulse stays remembered as evidence, however long it is until the frame run completes. A link pulse with `lp_inv`=0 counts as no evidence.
- R8: Once set, `pol_reversed` stays 1 until reset.
- R9: When `pol_reversed`=1 and `fix_en`=1, `rxd_out` is the inverse of `rxd_in`. In every other case `rxd_out` equals `rxd_in`, with no clock delay.
- R10: `pol_reversed` is reported whatever the value of `fix_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lp_stb | input | 1 | One-cycle strobe: a link pulse was received |
| lp_inv | input | 1 | Polarity of that pulse, 1 = inverted |
| eof_stb | input | 1 | One-cycle strobe: an end of frame was received |
| eof_neg | input | 1 | Sign of the tail after that end of frame, 1 = negative |
| fix_en | input | 1 | Allow correction of the data when reversal is known |
| rxd_in | input | 1 | Recovered serial data bit |
| pol_reversed | output | 1 | Pair reversal has been declared |
| rxd_out | output | 1 | Data bit after optional inversion |

## Verification
On every cycle, the assertions check several things. The frame count never exceeds its threshold, and a normal-tail frame clears it. Pulse evidence is never dropped early. The flag is sticky, and each rise of the flag is backed by both kinds of evidence. The data path inverts whenever correction is active. Only the bench's scenarios can show the rest: neither kind of evidence alone is enough, the arrival order is free, a restarted run really delays the decision, and a long run of frames does not wrap the count into missing a decision.

// File: rtl/rx_pol_pkg.sv
// Package: shared constants and helpers for the receive polarity block.
// Assumes: nothing beyond a standard elaborator.
package rx_pol_pkg;
    // Default number of consecutive negative-tail frames required
    localparam int unsigned DEF_RUN_THRESH = 4;

    // Width needed to hold a count from 0 to thresh inclusive
    function automatic int unsigned run_cnt_w(input int unsigned thresh);
        return (thresh < 1) ? 1 : $clog2(thresh + 1);
    endfunction
endpackage

// File: rtl/rx_pol_pulse_latch.sv
// Module: remembers that at least one inverted link pulse has arrived.
// Assumes: lp_stb is a one-cycle strobe; clear_i is a one-cycle request
// raised when the reversal decision is taken; clear wins over a new pulse.
module rx_pol_pulse_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic lp_stb,
    input  logic lp_inv,
    input  logic clear_i,
    output logic seen_o
);
    // Capture inverted-pulse evidence and hold it until cleared
    always_ff @(posedge clk) begin
        if (!rst_n)                seen_o <= 1'b0;
        else if (clear_i)          seen_o <= 1'b0;
        else if (lp_stb && lp_inv) seen_o <= 1'b1;
    end

    // R7: evidence is kept unless a decision clears it
    a_r7_evidence_held: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_o && !clear_i) |=> seen_o);
endmodule

// File: rtl/rx_pol_frame_run.sv
// Module: counts consecutive end-of-frame events with a negative tail.
// Assumes: eof_stb is a one-cycle strobe; the count saturates at THRESH.
module rx_pol_frame_run #(
    parameter int unsigned THRESH = 4,
    localparam int unsigned CW = rx_pol_pkg::run_cnt_w(THRESH)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic eof_stb,
    input  logic eof_neg,
    output logic full_o
);
    localparam logic [CW-1:0] LIMIT = CW'(THRESH);

    logic [CW-1:0] run_q;

    // Advance, saturate or restart the run on each end of frame
    always_ff @(posedge clk) begin
        if (!rst_n)                      run_q <= '0;
        else if (eof_stb && !eof_neg)    run_q <= '0;
        else if (eof_stb && run_q < LIMIT) run_q <= run_q + 1'b1;
    end

    // Run has reached the required length
    always_comb full_o = (run_q == LIMIT);

    // R6: count never passes the threshold
    a_r6_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= LIMIT);
    // R5: normal-tail frame restarts the run
    a_r5_run_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (eof_stb && !eof_neg) |=> (run_q == '0));
endmodule

// File: rtl/rx_pol_data_flip.sv
// Module: optionally inverts the recovered data bit, with no register.
// Assumes: flip_i is stable for the duration of the data it applies to.
module rx_pol_data_flip (
    input  logic flip_i,
    input  logic d_i,
    output logic d_o
);
    // Invert the stream when correction is active
    always_comb d_o = flip_i ? ~d_i : d_i;
endmodule

// File: rtl/rx_polarity_fixer.sv
// Module: top of the receive polarity detector and corrector.
// Declares a swapped pair once both an inverted link pulse and a run of
// RUN_THRESH negative-tail frames have been captured; the flag is sticky
// until reset. The data path inverts only when fix_en is also set.
// Assumes: strobes are single-cycle and already qualified upstream.
module rx_polarity_fixer #(
    parameter int unsigned RUN_THRESH = rx_pol_pkg::DEF_RUN_THRESH
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lp_stb,
    input  logic lp_inv,
    input  logic eof_stb,
    input  logic eof_neg,
    input  logic fix_en,
    input  logic rxd_in,
    output logic pol_reversed,
    output logic rxd_out
);
    logic pulse_seen;
    logic run_full;
    logic decide;
    logic flip;

    // Decision fires once, when both pieces of evidence are held
    always_comb decide = pulse_seen && run_full && !pol_reversed;
    // Correction active only with reversal known and enabled
    always_comb flip = pol_reversed && fix_en;

    rx_pol_pulse_latch u_pulse (
        .clk     (clk),
        .rst_n   (rst_n),
        .lp_stb  (lp_stb),
        .lp_inv  (lp_inv),
        .clear_i (decide),
        .seen_o  (pulse_seen)
    );

    rx_pol_frame_run #(.THRESH(RUN_THRESH)) u_run (
        .clk     (clk),
        .rst_n   (rst_n),
        .eof_stb (eof_stb),
        .eof_neg (eof_neg),
        .full_o  (run_full)
    );

    rx_pol_data_flip u_flip (
        .flip_i (flip),
        .d_i    (rxd_in),
        .d_o    (rxd_out)
    );

    // Sticky reversal status
    always_ff @(posedge clk) begin
        if (!rst_n)      pol_reversed <= 1'b0;
        else if (decide) pol_reversed <= 1'b1;
    end

    // R8: once declared, stays declared
    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        pol_reversed |=> pol_reversed);
    // R4: a rise is backed by both kinds of evidence
    a_r4_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pol_reversed) |-> $past(pulse_seen && run_full));
    // R9: data inverted whenever correction is active
    a_r9_data_inverted: assert property (@(posedge clk) disable iff (!rst_n)
        (pol_reversed && fix_en) |-> (rxd_out != rxd_in));
endmodule

// File: tb/rx_polarity_fixer_tb.sv
// Directed bench: one task per scenario, each checking its own results.
module rx_polarity_fixer_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lp_stb = 1'b0, lp_inv = 1'b0, eof_stb = 1'b0, eof_neg = 1'b0;
    logic fix_en = 1'b0, rxd_in = 1'b0;
    logic pol_reversed, rxd_out;
    int checks = 0, errors = 0;

    always #4 clk = ~clk;

    rx_polarity_fixer #(.RUN_THRESH(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .lp_stb(lp_stb), .lp_inv(lp_inv),
        .eof_stb(eof_stb), .eof_neg(eof_neg), .fix_en(fix_en),
        .rxd_in(rxd_in), .pol_reversed(pol_reversed), .rxd_out(rxd_out));

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; lp_stb = 0; eof_stb = 0;
        idle(2); rst_n = 1'b1;
    endtask

    task automatic pulse(input logic inv);
        lp_stb = 1'b1; lp_inv = inv; @(negedge clk); lp_stb = 1'b0;
    endtask

    task automatic frame(input logic neg);
        eof_stb = 1'b1; eof_neg = neg; @(negedge clk); eof_stb = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 flag", pol_reversed, 1'b0);
        fix_en = 1; rxd_in = 1; #1 chk("R1 pass", rxd_out, 1'b1);
        fix_en = 0;
    endtask

    task automatic t_frames_only();
        do_reset();
        for (int i = 0; i < 6; i++) frame(1'b1);
        pulse(1'b0); idle(3);
        chk("R2 frames only", pol_reversed, 1'b0);
        chk("R7 normal pulse ignored", pol_reversed, 1'b0);
    endtask

    task automatic t_pulses_only();
        do_reset();
        pulse(1'b1); pulse(1'b1); frame(1'b1); frame(1'b1); frame(1'b1); idle(3);
        chk("R3 pulses only", pol_reversed, 1'b0);
    endtask

    task automatic t_both();
        do_reset();
        pulse(1'b1);
        for (int i = 0; i < 4; i++) frame(1'b1);
        chk("R4 not before edge", pol_reversed, 1'b0);
        idle(1);
        chk("R4 declared", pol_reversed, 1'b1);
        frame(1'b0); pulse(1'b0); idle(5);
        chk("R8 sticky", pol_reversed, 1'b1);
    endtask

    task automatic t_order();
        do_reset();
        for (int i = 0; i < 4; i++) frame(1'b1);
        idle(20);
        chk("R4 frames first pending", pol_reversed, 1'b0);
        pulse(1'b1); idle(1);
        chk("R4 frames first declared", pol_reversed, 1'b1);
    endtask

    task automatic t_restart();
        do_reset();
        pulse(1'b1);
        for (int i = 0; i < 3; i++) frame(1'b1);
        frame(1'b0);
        for (int i = 0; i < 3; i++) frame(1'b1);
        idle(2);
        chk("R5 restarted run", pol_reversed, 1'b0);
        frame(1'b1); idle(1);
        chk("R5 full run after restart", pol_reversed, 1'b1);
    endtask

    task automatic t_saturate();
        do_reset();
        for (int i = 0; i < 8; i++) frame(1'b1);
        pulse(1'b1); idle(1);
        chk("R6 no wrap", pol_reversed, 1'b1);
    endtask

    task automatic t_held();
        do_reset();
        pulse(1'b1); idle(300);
        for (int i = 0; i < 4; i++) frame(1'b1);
        idle(1);
        chk("R7 evidence held", pol_reversed, 1'b1);
    endtask

    task automatic t_correct();
        do_reset();
        fix_en = 0;
        pulse(1'b1);
        for (int i = 0; i < 4; i++) frame(1'b1);
        idle(1);
        chk("R10 flag without fix", pol_reversed, 1'b1);
        rxd_in = 1; #1 chk("R9 pass when disabled", rxd_out, 1'b1);
        fix_en = 1;
        rxd_in = 1; #1 chk("R9 invert 1", rxd_out, 1'b0);
        rxd_in = 0; #1 chk("R9 invert 0", rxd_out, 1'b1);
        fix_en = 0; #1 chk("R9 back to pass", rxd_out, 1'b0);
    endtask

    initial begin
        t_reset(); t_frames_only(); t_pulses_only(); t_both(); t_order();
        t_restart(); t_saturate(); t_held(); t_correct();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule